// File: doc/BRIEF.md
# EEPROM Page Write Controller

This block sits behind the slave side of a two-wire serial memory. The protocol engine hands it decoded events: a bus START, a loaded word address, each received data byte and the closing STOP. Data bytes are collected in a page buffer of `2**PAGE_W` entries. Each entry carries its own written flag. The upper address bits choose the page and stay fixed for the transaction. The lower bits step after every byte and wrap inside the page.

A STOP commits the buffered bytes only if at least one byte was received and the write-protect input is low at that STOP. The commit starts a self-timed cycle. The block first waits `CYCLE_TICKS` clock ticks. It then walks the page one offset per tick and writes only the flagged entries into the byte-wide array. Throughout the cycle `busy_o` is high, and the protocol engine answers every device address with a NACK. This lets the host poll for completion. While busy, the block also ignores all bus events and array reads.

The array model starts with every location erased to 0xFF. It is read through a registered port. After each cycle, the block exports the address that follows the last byte written, with the page wrap applied.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, every array location reads 0xFF, `busy_o` is 0 and `cur_addr_o` is 0.
- R2: `addr_i[ADDR_W-1:PAGE_W]` selects the page and holds for the transaction. After each data byte, only `addr_i[PAGE_W-1:0]` (the offset) increments. Passing the last offset wraps to offset 0 of the same page, and a byte sent later to an offset replaces the earlier one.
- R3: Only offsets that received a byte are programmed. Every other byte of the page keeps its old value.
- R4: A STOP with no buffered byte starts no cycle. A START discards bytes buffered before it, so a repeated START followed by a STOP leaves the array unchanged.
- R5: `wp_i` is sampled in the STOP cycle. If it is 1, the buffered bytes are discarded and `busy_o` stays 0. A change of `wp_i` after an accepted STOP does not alter the running cycle.
- R6: After an accepted STOP edge, `busy_o` is high for exactly `CYCLE_TICKS + 2**PAGE_W` cycles. It falls on the same edge that writes the last page offset.
- R7: While `busy_o` is 1, `start_i`, `addr_load_i`, `data_valid_i`, `stop_i` and `rd_en_i` have no effect: `rd_data_o` holds and no array byte changes.
- R8: `cur_addr_o` changes only when a cycle completes. It then holds `{page, (last offset + 1) mod 2**PAGE_W}`.
- R9: A read with `rd_en_i` high and `busy_o` low returns the array byte at `rd_addr_i` on `rd_data_o` one clock later. A read issued on the first idle cycle returns the byte committed by the last edge of the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Pulse: a bus START was seen |
| addr_load_i | input | 1 | Pulse: word address is valid on `addr_i` |
| addr_i | input | ADDR_W | Word address of the transaction |
| data_valid_i | input | 1 | Pulse: a data byte is valid on `data_i` |
| data_i | input | DATA_W | Received data byte |
| stop_i | input | 1 | Pulse: a bus STOP was seen |
| wp_i | input | 1 | Write protect, 1 = inhibit programming |
| rd_en_i | input | 1 | Array read request |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | DATA_W | Registered read data |
| busy_o | output | 1 | Programming cycle in progress, NACK device addresses |
| cur_addr_o | output | ADDR_W | Address after the last programmed byte |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is the final commit and a read. The bench holds a read of the page's last offset through the whole cycle. It then checks two things: the data output is unchanged on the first idle cycle, and it shows the freshly committed byte one cycle later.

The second pair is a running cycle and new bus traffic. START, address, data and STOP pulses are fed one after another while busy. Afterwards, a full array sweep and the exported address confirm that none of them landed.

// File: rtl/epw_pkg.sv
package epw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_COMMIT = 2'd2
    } epw_state_e;
endpackage

// File: rtl/epw_page_buf.sv
module epw_page_buf #(
    parameter int PAGE_W = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_en_i,
    input  logic [PAGE_W-1:0] wr_off_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [PAGE_W-1:0] rd_off_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_valid_o,
    output logic              any_o
);
    localparam int PAGE = 1 << PAGE_W;

    logic [PAGE-1:0]   mask_d, mask_q;
    logic [DATA_W-1:0] slot_w [PAGE];

    // one storage register per page offset
    for (genvar g = 0; g < PAGE; g++) begin : g_slot
        logic [DATA_W-1:0] val_q;
        always_ff @(posedge clk) begin
            if (wr_en_i && (wr_off_i == PAGE_W'(g))) val_q <= wr_data_i;
        end
        assign slot_w[g] = val_q;
    end

    always_comb begin
        mask_d = mask_q;
        if (clr_i)        mask_d = '0;
        else if (wr_en_i) mask_d[wr_off_i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign rd_data_o  = slot_w[rd_off_i];
    assign rd_valid_o = mask_q[rd_off_i];
    assign any_o      = |mask_q;
endmodule

// File: rtl/epw_array.sv
module epw_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rdata_d, rdata_q;

    // erased state of every cell is all ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    always_comb begin
        rdata_d = rdata_q;
        if (re_i) rdata_d = mem_q[raddr_i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/epw_seq.sv
module epw_seq
    import epw_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 5,
    parameter int CYCLE_TICKS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              data_valid_i,
    input  logic              stop_i,
    input  logic              wp_i,
    input  logic              buf_any_i,
    input  logic              buf_bit_i,
    output logic              buf_clr_o,
    output logic              buf_wr_o,
    output logic [PAGE_W-1:0] buf_off_o,
    output logic [PAGE_W-1:0] commit_idx_o,
    output logic              arr_we_o,
    output logic [ADDR_W-1:0] arr_waddr_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] cur_addr_o
);
    localparam int PAGE_HI = ADDR_W - PAGE_W;
    localparam int CNT_W   = $clog2(CYCLE_TICKS + 1);

    typedef struct packed {
        epw_state_e          state;
        logic [PAGE_HI-1:0]  page;
        logic [PAGE_W-1:0]   off;
        logic [CNT_W-1:0]    cnt;
        logic [PAGE_W-1:0]   idx;
        logic [ADDR_W-1:0]   cur;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        buf_clr_o = 1'b0;
        buf_wr_o  = 1'b0;
        arr_we_o  = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    buf_clr_o = 1'b1;
                end else if (addr_load_i) begin
                    s_d.page = addr_i[ADDR_W-1:PAGE_W];
                    s_d.off  = addr_i[PAGE_W-1:0];
                end else if (data_valid_i) begin
                    buf_wr_o = 1'b1;
                    s_d.off  = s_q.off + 1'b1;  // wraps inside the page
                end else if (stop_i) begin
                    if (buf_any_i && !wp_i) begin
                        s_d.state = ST_WAIT;
                        s_d.cnt   = CNT_W'(CYCLE_TICKS - 1);
                    end else begin
                        buf_clr_o = 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (s_q.cnt == '0) begin
                    s_d.state = ST_COMMIT;
                    s_d.idx   = '0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_COMMIT: begin
                arr_we_o = buf_bit_i;
                s_d.idx  = s_q.idx + 1'b1;
                if (&s_q.idx) begin
                    s_d.state = ST_IDLE;
                    s_d.cur   = {s_q.page, s_q.off};
                    buf_clr_o = 1'b1;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ST_IDLE, '0, '0, '0, '0, '0};
        else        s_q <= s_d;
    end

    assign buf_off_o    = s_q.off;
    assign commit_idx_o = s_q.idx;
    assign arr_waddr_o  = {s_q.page, s_q.idx};
    assign busy_o       = (s_q.state != ST_IDLE);
    assign cur_addr_o   = s_q.cur;
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 5,
    parameter int DATA_W      = 8,
    parameter int CYCLE_TICKS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              addr_load_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              data_valid_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              stop_i,
    input  logic              wp_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] cur_addr_o
);
    logic              buf_clr_w, buf_wr_w, buf_any_w, buf_bit_w, arr_we_w;
    logic [PAGE_W-1:0] buf_off_w, commit_idx_w;
    logic [DATA_W-1:0] buf_data_w;
    logic [ADDR_W-1:0] arr_waddr_w;

    epw_seq #(
        .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CYCLE_TICKS(CYCLE_TICKS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_i), .addr_load_i(addr_load_i), .addr_i(addr_i),
        .data_valid_i(data_valid_i), .stop_i(stop_i), .wp_i(wp_i),
        .buf_any_i(buf_any_w), .buf_bit_i(buf_bit_w),
        .buf_clr_o(buf_clr_w), .buf_wr_o(buf_wr_w), .buf_off_o(buf_off_w),
        .commit_idx_o(commit_idx_w), .arr_we_o(arr_we_w),
        .arr_waddr_o(arr_waddr_w), .busy_o(busy_o), .cur_addr_o(cur_addr_o)
    );

    epw_page_buf #(
        .PAGE_W(PAGE_W), .DATA_W(DATA_W)
    ) u_buf (
        .clk(clk), .rst_n(rst_n),
        .clr_i(buf_clr_w), .wr_en_i(buf_wr_w), .wr_off_i(buf_off_w),
        .wr_data_i(data_i), .rd_off_i(commit_idx_w),
        .rd_data_o(buf_data_w), .rd_valid_o(buf_bit_w), .any_o(buf_any_w)
    );

    epw_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_arr (
        .clk(clk), .rst_n(rst_n),
        .we_i(arr_we_w), .waddr_i(arr_waddr_w), .wdata_i(buf_data_w),
        .re_i(rd_en_i && !busy_o), .raddr_i(rd_addr_i), .rdata_o(rd_data_o)
    );
endmodule

// File: rtl/epw_checker.sv
module epw_checker #(
    parameter int ADDR_W      = 11,
    parameter int PAGE_W      = 5,
    parameter int DATA_W      = 8,
    parameter int CYCLE_TICKS = 1000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              addr_load_i,
    input logic              data_valid_i,
    input logic              stop_i,
    input logic              wp_i,
    input logic              busy_o,
    input logic              buf_any,
    input logic [DATA_W-1:0] rd_data_o,
    input logic [ADDR_W-1:0] cur_addr_o
);
    localparam int RUN = CYCLE_TICKS + (1 << PAGE_W);

    logic [31:0] run_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_len_q <= '0;
        else        run_len_q <= busy_o ? run_len_q + 1 : '0;
    end

    p_empty_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !buf_any) |=> !busy_o);

    p_wp_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && stop_i && wp_i) |=> !busy_o);

    p_commit_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && stop_i && !wp_i && buf_any && !start_i && !addr_load_i && !data_valid_i)
        |=> busy_o);

    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_len_q == RUN));

    p_read_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(rd_data_o));

    p_cur_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_addr_o) |-> $fell(busy_o));
endmodule

bind eeprom_page_writer epw_checker #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .CYCLE_TICKS(CYCLE_TICKS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_load_i(addr_load_i),
    .data_valid_i(data_valid_i), .stop_i(stop_i), .wp_i(wp_i), .busy_o(busy_o),
    .buf_any(buf_any_w), .rd_data_o(rd_data_o), .cur_addr_o(cur_addr_o)
);

// File: tb/sim_eeprom_page_writer.sv
`timescale 1ns/1ps
module sim_eeprom_page_writer;
    localparam int AW = 8;
    localparam int PW = 5;
    localparam int PG = 1 << PW;
    localparam int TK = 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, addr_load_i = 0, data_valid_i = 0, stop_i = 0, wp_i = 0, rd_en_i = 0;
    logic [AW-1:0] addr_i = '0, rd_addr_i = '0;
    logic [7:0]    data_i = '0;
    logic [7:0]    rd_data_o;
    logic          busy_o;
    logic [AW-1:0] cur_addr_o;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] ref_mem [DEPTH];
    int exp_cur = 0;

    always #2.5 clk = ~clk;

    eeprom_page_writer #(.ADDR_W(AW), .PAGE_W(PW), .DATA_W(8), .CYCLE_TICKS(TK)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_load_i(addr_load_i),
        .addr_i(addr_i), .data_valid_i(data_valid_i), .data_i(data_i),
        .stop_i(stop_i), .wp_i(wp_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
        .rd_data_o(rd_data_o), .busy_o(busy_o), .cur_addr_o(cur_addr_o)
    );

    task automatic chk(string tag, int act, int expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
        end
    endtask

    task automatic finish_up();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // all tasks are entered and left at a falling edge
    task automatic read_byte(int a, output logic [7:0] v);
        rd_en_i = 1; rd_addr_i = AW'(a);
        @(negedge clk);
        rd_en_i = 0;
        v = rd_data_o;
    endtask

    task automatic sweep(string tag);
        logic [7:0] v;
        for (int a = 0; a < DEPTH; a++) begin
            read_byte(a, v);
            chk(tag, v, ref_mem[a]);
        end
    endtask

    task automatic pulse_start();
        start_i = 1; @(negedge clk); start_i = 0;
    endtask

    task automatic load_addr(int a);
        addr_load_i = 1; addr_i = AW'(a); @(negedge clk); addr_load_i = 0;
    endtask

    task automatic send_byte(logic [7:0] d);
        data_valid_i = 1; data_i = d; @(negedge clk); data_valid_i = 0;
    endtask

    task automatic send_stop(bit wp);
        wp_i = wp; stop_i = 1; @(negedge clk); stop_i = 0;
    endtask

    // full write transaction with a bench-side page model
    task automatic wr_txn(int addr, int n, int seed, bit wp);
        logic [7:0] pend [PG];
        bit         pmask [PG];
        int page, off;
        for (int k = 0; k < PG; k++) pmask[k] = 0;
        page = addr / PG;
        off  = addr % PG;
        pulse_start();
        load_addr(addr);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = 8'((seed + 7 * i) & 255);
            send_byte(d);
            pend[off]  = d;
            pmask[off] = 1;
            off = (off + 1) % PG;
        end
        send_stop(wp);
        if (!wp && n > 0) begin
            for (int k = 0; k < PG; k++)
                if (pmask[k]) ref_mem[page * PG + k] = pend[k];
            exp_cur = page * PG + off;
        end
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy_o && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #1_000_000;
        n_err++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_up();
    end

    initial begin
        int n;
        logic [7:0] prev, v;
        for (int a = 0; a < DEPTH; a++) ref_mem[a] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state and erased array
        chk("R1 busy after reset", busy_o, 0);
        chk("R8 cur_addr after reset", cur_addr_o, 0);
        sweep("R1 erased array");

        // R6 full page, busy window
        wr_txn(64, 32, 3, 0);
        chk("R6 busy after stop", busy_o, 1);
        wait_idle(n);
        chk("R6 busy length", n, TK + PG);
        chk("R8 cur_addr full page", cur_addr_o, exp_cur);
        sweep("R2 full page");

        // R2 wrap with overwrite
        wr_txn(5 * PG + 28, 40, 100, 0);
        wait_idle(n);
        chk("R6 busy length wrap", n, TK + PG);
        chk("R8 cur_addr wrap", cur_addr_o, 164);
        sweep("R2 wrap overwrite");

        // R3 partial page
        wr_txn(PG + 10, 3, 50, 0);
        wait_idle(n);
        chk("R8 cur_addr partial", cur_addr_o, PG + 13);
        sweep("R3 partial page");

        // R4 empty stop and repeated start
        pulse_start(); load_addr(96); send_stop(0);
        chk("R4 empty stop no busy", busy_o, 0);
        pulse_start(); load_addr(96); send_byte(8'h11); send_byte(8'h22);
        pulse_start(); send_stop(0);
        chk("R4 repeated start no busy", busy_o, 0);
        chk("R8 cur_addr unchanged", cur_addr_o, exp_cur);
        sweep("R4 discarded bytes");

        // R5 protect at stop, then change during cycle
        wr_txn(200, 4, 9, 1);
        chk("R5 protected no busy", busy_o, 0);
        wp_i = 0;
        wr_txn(224, 5, 77, 0);
        wp_i = 1;
        wait_idle(n);
        wp_i = 0;
        chk("R5 late protect busy length", n, TK + PG);
        sweep("R5 protect");

        // R7 traffic during busy, R9 read on first idle cycle
        read_byte(0, prev);
        wr_txn(4 * PG + 20, 12, 31, 0);
        rd_en_i = 1; rd_addr_i = AW'(4 * PG + 31);
        for (int k = 0; busy_o && k < 1000; k++) begin
            case (k)
                0: start_i = 1;
                1: begin addr_load_i = 1; addr_i = '0; end
                2: begin data_valid_i = 1; data_i = 8'h5A; end
                3: stop_i = 1;
                default: ;
            endcase
            @(negedge clk);
            start_i = 0; addr_load_i = 0; data_valid_i = 0; stop_i = 0;
            if (busy_o) chk("R7 read held while busy", rd_data_o, prev);
        end
        chk("R7 read held on release edge", rd_data_o, prev);
        @(negedge clk);
        chk("R9 read of last committed byte", rd_data_o, ref_mem[4 * PG + 31]);
        rd_en_i = 0;
        chk("R8 cur_addr after busy traffic", cur_addr_o, 4 * PG);
        chk("R4 no cycle from busy traffic", busy_o, 0);
        sweep("R7 busy traffic ignored");

        finish_up();
    end
endmodule